// File: doc/BRIEF.md
# Display Pattern RAM Host Port

This block sits between a host processor and the byte-wide pattern memory of a dot-matrix graphics controller. The panel is 112 by 80 one-bit dots, stored as 1120 bytes. The host drives a strobe together with a register-select line, a read/write line and a data byte. Through these signals it issues instructions, writes pattern bytes and reads them back. The block keeps an 11-bit address counter, a data register and a host read latch. It drives a synchronous single-port RAM that lives outside the block.

A written byte goes to memory in the same cycle as its strobe, and the counter then steps one place. The direction of that step is a mode bit. Reads are served ahead of time. An address-set instruction, and every data read, starts a RAM fetch into the data register. A data read returns what the read latch already holds, then moves the data register into the latch. The first read after an address set therefore returns a stale (dummy) byte, and later reads follow the address sequence. A second mode bit chooses whether reads move the counter. There is no busy flag. The host may strobe on every second clock cycle.

Top module: `disp_ram_port`

## Requirements
- R1: After reset the address counter is 0, it counts upward, reads leave it in place, `rdata_o` is 0 and no RAM access is issued.
- R2: Instruction `1lll_llll` (rs=0, rw=0) loads the counter with {high stage, lll_llll}. The high stage holds 4 bits. The same strobe cycle issues a RAM read at the loaded address. A loaded value of 1120 or more loads 0.
- R3: A data write (rs=1, rw=0) drives `ram_en_o`=1, `ram_we_o`=1, `ram_addr_o` equal to the counter and `ram_wdata_o` equal to the host byte, all in the strobe cycle.
- R4: After each data write the counter moves by one, upward when the direction bit is 0 and downward when it is 1. It wraps from 1119 to 0 and from 0 to 1119.
- R5: A data read (rs=1, rw=1) returns on `rdata_o`, in its strobe cycle, the byte moved into the read latch by the previous read. The first read after an address set is therefore a dummy, and each later read returns the byte at the next address in sequence.
- R6: With the read-update bit set, a read moves the counter like a write does and prefetches the new address. With the bit clear, the counter holds and the same address is prefetched again, so repeated reads return the same byte.
- R7: Instruction `0001_hhhh` stores hhhh in the high stage without moving the counter. Instruction `0010_xxud` sets the direction bit to d and the read-update bit to u. Neither issues a RAM access.
- R8: The combination rs=0, rw=1 and any other instruction byte (top nibble 0000, 0011 to 0111) change nothing and issue no RAM access.
- R9: Strobes one idle cycle apart are all accepted with no wait. Each fetch has landed in the data register before the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | One-cycle host access strobe |
| rs_i | input | 1 | Register select: 0 instruction, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read latch |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 11 | RAM byte address |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte, one cycle after the access |

## Verification
The cases hardest to reach from the ports are the counter wrap at both ends and the dummy byte, whose value depends on the read before it. To reach them, the bench first fills all 1120 bytes with an arithmetic pattern through sequential writes. It then reads the whole memory back across the upper wrap, and sweeps downward through address 0. It also repeats reads in hold mode and loads an out-of-range address. A reference model in the bench predicts every dummy byte from the previous read.

// File: rtl/disp_port_pkg.sv
package disp_port_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_SET_HI, OP_SET_LO, OP_MODE, OP_WRITE, OP_READ
  } host_op_e;
endpackage

// File: rtl/hp_decode.sv
module hp_decode
  import disp_port_pkg::*;
(
  input  logic       stb_i,
  input  logic       rs_i,
  input  logic       rw_i,
  input  logic [3:0] instr_hi_i,
  output host_op_e   op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (stb_i) begin
      unique case ({rs_i, rw_i})
        2'b00: begin
          if (instr_hi_i[3])            op_o = OP_SET_LO;
          else if (instr_hi_i == 4'h1)  op_o = OP_SET_HI;
          else if (instr_hi_i == 4'h2)  op_o = OP_MODE;
          else                          op_o = OP_NONE;
        end
        2'b10:   op_o = OP_WRITE;
        2'b11:   op_o = OP_READ;
        default: op_o = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hp_addr_ctr.sv
module hp_addr_ctr
  import disp_port_pkg::*;
#(
  parameter int DEPTH = 1120,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_op_e      op_i,
  input  logic [6:0]    data_i,
  output logic [AW-1:0] ac_o,
  output logic [AW-1:0] addr_o,
  output logic          dec_o,
  output logic          rdm_o
);
  localparam int HI_W = AW - 7;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]   ac_q, ac_nxt, load_addr, step_addr;
  logic [HI_W-1:0] hi_q;
  logic            dec_q, rdm_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign step_addr = dec_q ? ac_q - 1'b1 : ac_q + 1'b1;
    end else begin : g_wrap
      assign step_addr = dec_q ? ((ac_q == '0) ? LAST : ac_q - 1'b1)
                               : ((ac_q == LAST) ? '0 : ac_q + 1'b1);
    end
  endgenerate

  // out-of-range loads fall back to 0
  always_comb begin
    load_addr = {hi_q, data_i};
    if (load_addr > LAST) load_addr = '0;
  end

  always_comb begin
    unique case (op_i)
      OP_SET_LO: ac_nxt = load_addr;
      OP_WRITE:  ac_nxt = step_addr;
      OP_READ:   ac_nxt = rdm_q ? step_addr : ac_q;
      default:   ac_nxt = ac_q;
    endcase
  end

  // writes use the current counter, fetches use the updated one
  assign addr_o = (op_i == OP_WRITE) ? ac_q : ac_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q  <= '0;
      hi_q  <= '0;
      dec_q <= 1'b0;
      rdm_q <= 1'b0;
    end else begin
      ac_q <= ac_nxt;
      if (op_i == OP_SET_HI) hi_q <= data_i[HI_W-1:0];
      if (op_i == OP_MODE) begin
        dec_q <= data_i[0];
        rdm_q <= data_i[1];
      end
    end
  end

  assign ac_o  = ac_q;
  assign dec_o = dec_q;
  assign rdm_o = rdm_q;
endmodule

// File: rtl/hp_data_path.sv
module hp_data_path
  import disp_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_op_e      op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [DW-1:0] dr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] dr_q, latch_q;
  logic          fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q    <= '0;
      latch_q <= '0;
      fill_q  <= 1'b0;
    end else begin
      fill_q <= (op_i == OP_SET_LO) || (op_i == OP_READ);
      if (op_i == OP_WRITE) dr_q <= wdata_i;
      else if (fill_q)      dr_q <= ram_rdata_i;
      if (op_i == OP_READ)  latch_q <= dr_q;
    end
  end

  assign dr_o    = dr_q;
  assign rdata_o = latch_q;
endmodule

// File: rtl/disp_ram_port.sv
module disp_ram_port
  import disp_port_pkg::*;
#(
  parameter int DOTS_X = 112,
  parameter int DOTS_Y = 80,
  parameter int DW     = 8,
  localparam int DEPTH = DOTS_X * DOTS_Y / DW,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          rs_i,
  input  logic          rw_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic [DW-1:0] ram_rdata_i
);
  host_op_e      op;
  logic [AW-1:0] ac, addr;
  logic          dec, rdm;
  logic [DW-1:0] dr;

  hp_decode u_decode (
    .stb_i      (stb_i),
    .rs_i       (rs_i),
    .rw_i       (rw_i),
    .instr_hi_i (wdata_i[7:4]),
    .op_o       (op)
  );

  hp_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .data_i (wdata_i[6:0]),
    .ac_o   (ac),
    .addr_o (addr),
    .dec_o  (dec),
    .rdm_o  (rdm)
  );

  hp_data_path #(.DW(DW)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .wdata_i     (wdata_i),
    .ram_rdata_i (ram_rdata_i),
    .dr_o        (dr),
    .rdata_o     (rdata_o)
  );

  assign ram_en_o    = (op == OP_SET_LO) || (op == OP_WRITE) || (op == OP_READ);
  assign ram_we_o    = (op == OP_WRITE);
  assign ram_addr_o  = addr;
  assign ram_wdata_o = wdata_i;
endmodule

// File: rtl/disp_port_chk.sv
module disp_port_chk #(
  parameter int DEPTH = 1120,
  parameter int AW    = 11,
  parameter int DW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stb_i,
  input logic          rs_i,
  input logic          rw_i,
  input logic          ram_en_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ac,
  input logic          rdm,
  input logic [DW-1:0] dr,
  input logic [DW-1:0] rdata_o
);
  a_r4_ac_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ac) < DEPTH);

  a_r3_we_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_en_o && stb_i && rs_i && !rw_i);

  a_r4_write_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && rs_i && !rw_i) |=> ac != $past(ac));

  a_r6_hold_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && rs_i && rw_i && !rdm) |=> $stable(ac));

  a_r5_latch_from_dr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && rs_i && rw_i) |=> rdata_o == $past(dr));

  a_r8_unused_no_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !rs_i && rw_i) |-> !ram_en_o);

  a_r8_unused_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !rs_i && rw_i) |=> $stable(ac) && $stable(rdata_o) && $stable(dr));

  a_r9_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> !stb_i);
endmodule

bind disp_ram_port disp_port_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stb_i    (stb_i),
  .rs_i     (rs_i),
  .rw_i     (rw_i),
  .ram_en_o (ram_en_o),
  .ram_we_o (ram_we_o),
  .ac       (ac),
  .rdm      (rdm),
  .dr       (dr),
  .rdata_o  (rdata_o)
);

// File: tb/disp_ram_port_bench.sv
module disp_ram_port_bench;
  localparam int DEPTH = 1120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata, ram_wd, ram_rd;
  logic        ram_en, ram_we;
  logic [10:0] ram_addr;

  int checks = 0, fails = 0;
  logic [7:0] mem     [0:DEPTH-1];
  logic [7:0] ref_mem [0:DEPTH-1];
  int exp_ac = 0, exp_hi = 0, exp_dec = 0, exp_rdm = 0;
  logic [7:0] exp_dr = '0, exp_latch = '0;

  always #10 clk = ~clk;

  disp_ram_port u_disp_ram_port (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .rs_i(rs), .rw_i(rw),
    .wdata_i(wd), .rdata_o(rdata), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wd), .ram_rdata_i(ram_rd)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wd;
      else        ram_rd <= mem[ram_addr];
    end
  end

  function automatic int step(int a, int down);
    if (down != 0) return (a == 0) ? DEPTH - 1 : a - 1;
    return (a == DEPTH - 1) ? 0 : a + 1;
  endfunction

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 5) + 11) & 255);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic host(bit r_s, bit r_w, logic [7:0] d, string tag);
    int la;
    @(negedge clk);
    stb = 1'b1; rs = r_s; rw = r_w; wd = d;
    #5;
    if (!r_s && !r_w) begin
      if (d[7]) begin
        la = exp_hi * 128 + int'(d[6:0]);
        if (la >= DEPTH) la = 0;
        chk(ram_en && !ram_we && int'(ram_addr) == la, {tag, " R2 set"}, int'(ram_addr), la);
        exp_ac = la;
        exp_dr = ref_mem[la];
      end else if (d[7:4] == 4'h1) begin
        chk(!ram_en, {tag, " R7 hi"}, int'(ram_en), 0);
        exp_hi = int'(d[3:0]);
      end else if (d[7:4] == 4'h2) begin
        chk(!ram_en, {tag, " R7 mode"}, int'(ram_en), 0);
        exp_dec = int'(d[0]);
        exp_rdm = int'(d[1]);
      end else begin
        chk(!ram_en, {tag, " R8 unknown"}, int'(ram_en), 0);
      end
    end else if (!r_s && r_w) begin
      chk(!ram_en, {tag, " R8 unused"}, int'(ram_en), 0);
    end else if (!r_w) begin
      chk(ram_en && ram_we && int'(ram_addr) == exp_ac && ram_wd == d,
          {tag, " R3 R4 write"}, int'(ram_addr), exp_ac);
      ref_mem[exp_ac] = d;
      exp_dr = d;
      exp_ac = step(exp_ac, exp_dec);
    end else begin
      chk(rdata == exp_latch, {tag, " R5 R9 read"}, int'(rdata), int'(exp_latch));
      exp_latch = exp_dr;
      if (exp_rdm != 0) exp_ac = step(exp_ac, exp_dec);
      chk(ram_en && !ram_we && int'(ram_addr) == exp_ac, {tag, " R6 fetch"},
          int'(ram_addr), exp_ac);
      exp_dr = ref_mem[exp_ac];
    end
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic set_addr(int a, string tag);
    host(1'b0, 1'b0, 8'h10 | 8'(a >> 7), tag);
    host(1'b0, 1'b0, 8'h80 | 8'(a & 127), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    #5;
    chk(rdata == 8'h00, "R1 rdata reset", int'(rdata), 0);
    chk(!ram_en, "R1 no access in reset", int'(ram_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(rdata == 8'h00 && !ram_en, "R1 idle after reset", int'(rdata), 0);

    // R1: counter starts at 0 counting up, reads hold
    host(1'b1, 1'b0, 8'hA5, "R1 first write");
    host(1'b1, 1'b0, 8'h5A, "R1 second write");
    host(1'b1, 1'b1, 8'h00, "R1 read");
    host(1'b1, 1'b1, 8'h00, "R1 read hold");

    // full fill, then upper wrap
    set_addr(0, "R2");
    for (int a = 0; a < DEPTH; a++) host(1'b1, 1'b0, pat(a), "R4 fill");
    host(1'b1, 1'b0, pat(0), "R4 wrap up");

    // sequential read sweep across the upper wrap
    host(1'b0, 1'b0, 8'h22, "R7");
    set_addr(0, "R5");
    for (int a = 0; a <= DEPTH + 1; a++) host(1'b1, 1'b1, 8'h00, "R5 sweep");

    // downward reads through address 0
    host(1'b0, 1'b0, 8'h23, "R7");
    set_addr(5, "R6");
    for (int a = 0; a < 10; a++) host(1'b1, 1'b1, 8'h00, "R6 down");

    // hold mode reads
    host(1'b0, 1'b0, 8'h20, "R7");
    set_addr(300, "R6");
    for (int a = 0; a < 4; a++) host(1'b1, 1'b1, 8'h00, "R6 hold");

    // ignored accesses
    host(1'b0, 1'b1, 8'hFF, "R8");
    host(1'b0, 1'b0, 8'h40, "R8");
    host(1'b0, 1'b0, 8'h00, "R8");
    host(1'b0, 1'b0, 8'h35, "R8");
    host(1'b1, 1'b1, 8'h00, "R8 after ignored");

    // downward writes through 0, then upward reads across the wrap
    host(1'b0, 1'b0, 8'h21, "R7");
    set_addr(0, "R4");
    host(1'b1, 1'b0, 8'h11, "R4 down");
    host(1'b1, 1'b0, 8'h22, "R4 down wrap");
    host(1'b0, 1'b0, 8'h22, "R7");
    set_addr(DEPTH - 1, "R5");
    for (int a = 0; a < 3; a++) host(1'b1, 1'b1, 8'h00, "R5 wrap read");

    // out-of-range load and the last valid address
    host(1'b0, 1'b0, 8'h18, "R2");
    host(1'b0, 1'b0, 8'hFF, "R2 out of range");
    host(1'b1, 1'b0, 8'h77, "R2 after clamp");
    host(1'b0, 1'b0, 8'hDF, "R2 last");
    host(1'b1, 1'b0, 8'h66, "R2 write last");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule